// File: doc/BRIEF.md
# Multiplexed Byte-Wide DRAM Controller with Refresh

This block connects a simple byte-wide processor-style bus to a bank of eight 16K x 1 dynamic RAM devices. The eight devices share every control and address line and each holds one bit of the byte. The bus supplies a 14-bit address, write data and separate read and write strobes. The controller time-multiplexes the row and then the column half of the address onto one shared 7-bit bus, and drives active-low row strobe, column strobe and write enable.

A free-running timer raises a refresh request once per interval. The interval is a clock-count parameter; its default of 3900 clocks is about 15.6 us at 250 MHz, which covers all 128 rows in 2 ms. Refresh is row-strobe-only. The row comes from an internal 7-bit counter that advances after each refresh and wraps to zero.

If a request is pending when the controller is idle, a plain refresh runs before any bus access, and the bus is stalled until ready. If the request appears while a read is under way, the refresh is hidden. The column strobe stays low after the read, so the read data stays valid, while the row strobe is cycled again with the refresh row.

Top module: `dram_ctl`

## Requirements
- R1: While reset is held, the row strobe, column strobe and write enable outputs are high, bus_ready is low and the data output enable is low.
- R2: For an access, the row address (bus address bits 13 to 7) is on dram_a when the row strobe falls, and the column (bits 6 to 0) is on dram_a when the column strobe falls.
- R3: The column strobe falls exactly T_RCD clocks after the row strobe falls, and only while the row strobe is low. Before every falling edge of the row strobe it has been high for at least T_RP clocks.
- R4: For a write, write enable is already low in the clock before the column strobe falls. It stays low, with the output enable asserted and the write data held stable, for the whole column-low time (early write).
- R5: bus_ready is a one-clock pulse that ends each access. For a read, bus_rdata in that clock holds the byte that the devices drove while the column strobe was low.
- R6: A plain refresh pulses the row strobe low while the column strobe stays high, with the refresh row on dram_a. Successive refreshes use rows 0, 1, 2 and so on, and the row wraps from 127 to 0.
- R7: The gap between successive refreshes never exceeds REF_INTERVAL clocks plus the length of one access. A timer expiry never finds an earlier request still unserviced.
- R8: If a refresh request and a bus request are both pending while the controller is idle, the refresh starts first. bus_ready is deferred until the access completes after it.
- R9: If a refresh request is pending when a read finishes, the row strobe rises and falls again with the refresh row on dram_a while the column strobe stays low. The read data returned is unaffected.
- R10: With no bus request and no refresh in progress, both strobes are high (standby), and the column strobe never falls without a bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read request, held until bus_ready |
| bus_wr | input | 1 | Write request, held until bus_ready |
| bus_addr | input | 14 | Byte address: row in bits 13:7, column in bits 6:0 |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | One-clock completion pulse |
| bus_rdata | output | 8 | Read data, valid with bus_ready |
| dram_a | output | 7 | Multiplexed row/column/refresh address |
| dram_ras_n | output | 1 | Active-low row strobe |
| dram_cas_n | output | 1 | Active-low column strobe |
| dram_we_n | output | 1 | Active-low write enable |
| dram_dq_out | output | 8 | Write data toward the devices |
| dram_dq_oe | output | 1 | High while the controller drives the data lines |
| dram_dq_in | input | 8 | Read data from the devices |

## Verification
The assertions assume the bus side follows a held-request handshake. A request holds its strobe, address and data steady until bus_ready, then drops in the next clock, and read and write are never asserted together. They also assume one access plus one refresh fits well inside a refresh interval, so a pending request is always serviced before the timer expires again. The bench drives every access through one task that raises a single strobe, waits for the ready pulse and lowers it at once. It uses a 60-clock refresh interval, which is many times longer than one access.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    S_IDLE,   // standby, both strobes high
    S_ACT,    // row on bus, row strobe low
    S_CAS,    // column on bus, column strobe low
    S_PRE,    // both strobes high, precharge
    S_REF,    // plain refresh, row strobe only
    S_HPRE,   // hidden: row strobe high, column strobe held low
    S_HRAS    // hidden: row strobe low again with refresh row
  } seq_state_t;

  typedef enum logic [1:0] {
    AS_ROW,
    AS_COL,
    AS_REF
  } addr_sel_t;
endpackage

// File: rtl/dram_refresh.sv
module dram_refresh #(
  parameter int ROW_W        = 7,
  parameter int REF_INTERVAL = 3900
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_done,
  output logic             ref_req,
  output logic [ROW_W-1:0] ref_row
);
  localparam int CNT_W = $clog2(REF_INTERVAL + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_INTERVAL - 1);

  logic [CNT_W-1:0] tmr;
  logic             tick;

  assign tick = (tmr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr <= '0;
    end else if (tick) begin
      tmr <= '0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_req <= 1'b0;
    end else begin
      if (ref_done) ref_req <= 1'b0;
      if (tick)     ref_req <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_row <= '0;
    end else if (ref_done) begin
      ref_row <= ref_row + 1'b1;
    end
  end

  // R6: the row after the last one is row zero
  p_row_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (ref_done && ref_row == {ROW_W{1'b1}}) |=> (ref_row == '0));

  // R7: no request may still be waiting when the next one is due
  p_req_serviced_r7: assert property (@(posedge clk) disable iff (rst)
    tick |-> (!ref_req || ref_done));
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_pkg::*;
#(
  parameter int ROW_W = 7,
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  addr_sel_t        sel_nx,
  input  logic [ROW_W-1:0] row_nx,
  input  logic [COL_W-1:0] col_nx,
  input  logic [ROW_W-1:0] ref_row,
  output logic [ROW_W-1:0] dram_a
);
  localparam int A_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [A_W-1:0] a_nx;

  always_comb begin
    unique case (sel_nx)
      AS_COL:  a_nx = A_W'(col_nx);
      AS_REF:  a_nx = A_W'(ref_row);
      default: a_nx = A_W'(row_nx);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) dram_a <= '0;
    else     dram_a <= a_nx[ROW_W-1:0];
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pkg::*;
#(
  parameter int ROW_W    = 7,
  parameter int COL_W    = 7,
  parameter int DATA_W   = 8,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int T_RP     = 2,
  parameter int T_REFRAS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [ROW_W+COL_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic                   bus_ready,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic                   ref_req,
  output logic                   ref_done,
  input  logic [DATA_W-1:0]      dram_dq_in,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  output addr_sel_t              sel_nx,
  output logic [ROW_W-1:0]       row_nx,
  output logic [COL_W-1:0]       col_nx
);
  localparam int AW   = ROW_W + COL_W;
  localparam int TM1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM2  = (T_RP > T_REFRAS) ? T_RP : T_REFRAS;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);

  seq_state_t        st, st_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic [AW-1:0]     addr_q, addr_nx;
  logic              wr_q, wr_nx;
  logic [DATA_W-1:0] wdata_nx;
  logic              accept, last, we_ph_nx;

  assign accept   = (st == S_IDLE) && !ref_req && (bus_rd || bus_wr);
  assign last     = (cnt == '0);
  assign addr_nx  = accept ? bus_addr : addr_q;
  assign wr_nx    = accept ? bus_wr : wr_q;
  assign wdata_nx = accept ? bus_wdata : dram_dq_out;
  assign row_nx   = addr_nx[AW-1:COL_W];
  assign col_nx   = addr_nx[COL_W-1:0];
  assign ref_done = ((st == S_REF) || (st == S_HRAS)) && last;

  always_comb begin
    st_n  = st;
    cnt_n = last ? cnt : cnt - 1'b1;
    unique case (st)
      S_IDLE: begin
        if (ref_req) begin
          st_n  = S_REF;
          cnt_n = CW'(T_REFRAS - 1);
        end else if (bus_rd || bus_wr) begin
          st_n  = S_ACT;
          cnt_n = CW'(T_RCD - 1);
        end
      end
      S_ACT: if (last) begin
        st_n  = S_CAS;
        cnt_n = CW'(T_CAS - 1);
      end
      S_CAS: if (last) begin
        st_n  = (!wr_q && ref_req) ? S_HPRE : S_PRE;
        cnt_n = CW'(T_RP - 1);
      end
      S_HPRE: if (last) begin
        st_n  = S_HRAS;
        cnt_n = CW'(T_REFRAS - 1);
      end
      S_REF, S_HRAS: if (last) begin
        st_n  = S_PRE;
        cnt_n = CW'(T_RP - 1);
      end
      S_PRE: if (last) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_n)
      S_CAS:                 sel_nx = AS_COL;
      S_REF, S_HPRE, S_HRAS: sel_nx = AS_REF;
      default:               sel_nx = AS_ROW;
    endcase
  end

  assign we_ph_nx = wr_nx && ((st_n == S_ACT) || (st_n == S_CAS));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cnt         <= '0;
      addr_q      <= '0;
      wr_q        <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_dq_out <= '0;
      bus_ready   <= 1'b0;
      bus_rdata   <= '0;
    end else begin
      st          <= st_n;
      cnt         <= cnt_n;
      addr_q      <= addr_nx;
      wr_q        <= wr_nx;
      dram_ras_n  <= !((st_n == S_ACT) || (st_n == S_CAS) ||
                       (st_n == S_REF) || (st_n == S_HRAS));
      dram_cas_n  <= !((st_n == S_CAS) || (st_n == S_HPRE) ||
                       (st_n == S_HRAS));
      dram_we_n   <= !we_ph_nx;
      dram_dq_oe  <= we_ph_nx;
      dram_dq_out <= wdata_nx;
      bus_ready   <= (st == S_CAS) && last;
      if ((st == S_CAS) && last && !wr_q) bus_rdata <= dram_dq_in;
    end
  end

  // R3: column strobe only falls under a low row strobe
  p_cas_under_ras_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> !dram_ras_n);

  // R4: early write, enable low one clock before the column strobe falls
  p_early_we_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

  // R5: completion is a single-clock pulse
  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);

  // R8: refresh wins over a bus request seen in idle
  p_ref_first_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && ref_req && (bus_rd || bus_wr)) |=> (st == S_REF));

  // R10: standby leaves both strobes high after precharge
  p_standby_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_PRE && last) |=> (dram_ras_n && dram_cas_n));
endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
  import dram_pkg::*;
#(
  parameter int ROW_W        = 7,
  parameter int COL_W        = 7,
  parameter int DATA_W       = 8,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_REFRAS     = 2,
  parameter int REF_INTERVAL = 3900
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [ROW_W+COL_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic                   bus_ready,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [ROW_W-1:0]       dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  logic             ref_req, ref_done;
  logic [ROW_W-1:0] ref_row;
  addr_sel_t        sel_nx;
  logic [ROW_W-1:0] row_nx;
  logic [COL_W-1:0] col_nx;

  dram_refresh #(.ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst(rst), .ref_done(ref_done),
    .ref_req(ref_req), .ref_row(ref_row)
  );

  dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_RP(T_RP), .T_REFRAS(T_REFRAS)
  ) u_seq (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .ref_req(ref_req), .ref_done(ref_done),
    .dram_dq_in(dram_dq_in), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .sel_nx(sel_nx), .row_nx(row_nx), .col_nx(col_nx)
  );

  dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
    .clk(clk), .rst(rst), .sel_nx(sel_nx), .row_nx(row_nx),
    .col_nx(col_nx), .ref_row(ref_row), .dram_a(dram_a)
  );

  // R9: a row strobe fall under a low column strobe carries the refresh row
  p_hidden_row_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_ras_n) && !dram_cas_n) |-> (dram_a == $past(ref_row)));
endmodule

// File: tb/sim_dram_ctl.sv
`timescale 1ns/1ps
module sim_dram_ctl;
  localparam int T_RCD   = 2;
  localparam int T_CAS   = 2;
  localparam int T_RP    = 2;
  localparam int T_REFR  = 2;
  localparam int REF_INT = 60;
  localparam int NVEC    = 12;

  // {write, addr[13:0], data[7:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 14'h0000, 8'h11}, {1'b1, 14'h3FFF, 8'hEE},
    {1'b1, 14'h007F, 8'h5A}, {1'b1, 14'h3F80, 8'hA5},
    {1'b1, 14'h0081, 8'h3C}, {1'b1, 14'h0101, 8'hC3},
    {1'b0, 14'h0000, 8'h11}, {1'b0, 14'h3FFF, 8'hEE},
    {1'b0, 14'h007F, 8'h5A}, {1'b0, 14'h3F80, 8'hA5},
    {1'b0, 14'h0081, 8'h3C}, {1'b0, 14'h0101, 8'hC3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_ready;
  logic [7:0]  bus_rdata;
  logic [6:0]  dram_a;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [7:0]  dram_dq_out, dram_dq_in;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dram_ctl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
             .T_REFRAS(T_REFR), .REF_INTERVAL(REF_INT)) u0 (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .dram_a(dram_a), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Device bank model and protocol monitor
  logic [7:0] mem [16384];
  logic [6:0] row_l = '0, col_l = '0, ref_exp = '0;
  logic [7:0] wdat_l = '0;
  bit  ras_p = 1'b1, cas_p = 1'b1, we_p = 1'b1, cas_seen = 1'b0;
  bit  req_at_fall = 1'b0, idle_phase = 1'b0;
  int  cyc = 0, ras_hi = 100, ras_fall_cyc = 0, last_ref = 0;
  int  ref_cnt = 0, hid_cnt = 0, plain_cnt = 0, pri_cnt = 0, idle_cas = 0;

  assign dram_dq_in = (!dram_cas_n && dram_we_n) ? mem[{row_l, col_l}] : 8'h00;

  task automatic ref_event();
    if (ref_cnt > 0)
      chk((cyc - last_ref) <= REF_INT + 16, "R7 refresh gap",
          32'(cyc - last_ref), 32'(REF_INT + 16));
    last_ref = cyc;
    ref_exp  = ref_exp + 7'd1;
    ref_cnt++;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (ras_p && !dram_ras_n) begin
        chk(ras_hi >= T_RP, "R3 precharge", 32'(ras_hi), 32'(T_RP));
        if (!dram_cas_n) begin
          chk(dram_a == ref_exp, "R9 hidden row", 32'(dram_a), 32'(ref_exp));
          hid_cnt++;
          ref_event();
        end else begin
          row_l        = dram_a;
          cas_seen     = 1'b0;
          req_at_fall  = bus_rd || bus_wr;
          ras_fall_cyc = cyc;
        end
      end
      if (dram_ras_n) ras_hi++; else ras_hi = 0;
      if (cas_p && !dram_cas_n) begin
        if (idle_phase) idle_cas++;
        chk(!dram_ras_n && (cyc - ras_fall_cyc) == T_RCD, "R3 ras-to-cas",
            32'(cyc - ras_fall_cyc), 32'(T_RCD));
        col_l    = dram_a;
        cas_seen = 1'b1;
        chk({row_l, col_l} == bus_addr, "R2 row/col split",
            32'({row_l, col_l}), 32'(bus_addr));
        if (!dram_we_n) begin
          chk(!we_p && dram_dq_oe, "R4 early write", 32'(we_p), 32'(0));
          mem[{row_l, col_l}] = dram_dq_out;
          wdat_l = dram_dq_out;
        end
      end else if (!cas_p && !dram_cas_n && cas_seen && !dram_ras_n &&
                   bus_wr) begin
        chk(!dram_we_n && dram_dq_oe && dram_dq_out == wdat_l,
            "R4 write hold", 32'(dram_dq_out), 32'(wdat_l));
      end
      if (!ras_p && dram_ras_n && dram_cas_n && !cas_seen) begin
        chk(row_l == ref_exp, "R6 refresh row", 32'(row_l), 32'(ref_exp));
        plain_cnt++;
        if (req_at_fall) pri_cnt++;
        ref_event();
      end
      ras_p = dram_ras_n;
      cas_p = dram_cas_n;
      we_p  = dram_we_n;
    end
  end

  task automatic access(input bit wr, input logic [13:0] a,
                        input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d;
    do @(negedge clk); while (!bus_ready);
    q = bus_rdata;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    logic [7:0] q;
    for (int i = 0; i < 16384; i++) mem[i] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && !bus_ready && !dram_dq_oe,
        "R1 reset outputs",
        {27'd0, dram_ras_n, dram_cas_n, dram_we_n, bus_ready, dram_dq_oe},
        32'h1C);
    rst = 1'b0;

    // table of vectors
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][22], VEC[i][21:8], VEC[i][7:0], q);
      if (!VEC[i][22])
        chk(q == VEC[i][7:0], "R5 read data", 32'(q), 32'(VEC[i][7:0]));
      @(negedge clk);
      chk(!bus_ready, "R5 ready pulse", 32'(bus_ready), 32'(0));
    end

    // fill a block, then read it back continuously (hidden refresh)
    for (int i = 0; i < 64; i++)
      access(1'b1, 14'((i * 263) & 14'h3FFF), 8'(i * 7 + 3), q);
    for (int n = 0; n < 900; n++) begin
      access(1'b0, 14'(((n % 64) * 263) & 14'h3FFF), 8'h00, q);
      chk(q == 8'((n % 64) * 7 + 3), "R9 read beside refresh",
          32'(q), 32'((n % 64) * 7 + 3));
    end
    chk(hid_cnt > 0, "R9 hidden refresh seen", 32'(hid_cnt), 32'(1));
    chk(pri_cnt > 0, "R8 refresh before pending access", 32'(pri_cnt), 32'(1));

    // quiet period: refresh only
    idle_phase = 1'b1;
    repeat (REF_INT * 20) @(negedge clk);
    idle_phase = 1'b0;
    chk(idle_cas == 0, "R10 no column strobe in standby", 32'(idle_cas), 32'(0));
    while (!(dram_ras_n && dram_cas_n)) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R10 standby strobes",
        {29'd0, dram_ras_n, dram_cas_n, dram_we_n}, 32'h7);
    chk(plain_cnt > 0, "R6 plain refresh seen", 32'(plain_cnt), 32'(1));
    chk(ref_cnt > 130, "R6 row counter wrapped", 32'(ref_cnt), 32'(131));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule